// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between a CAN bit sampler and a frame parser. It receives one sampled bus bit at a time, marked by a valid strobe. For each such bit it decides whether the bit is a stuff bit inserted by the transmitter. A stuff bit is dropped. Any other bit is passed on as a frame bit, tagged with its position in the frame.

The decision looks at a window of the six most recent raw bits. Stuff bits that were already dropped still count in this window. The parser may hand back the index of the last data bit once it has decoded the data length. From that point on, stuffing stops at a fixed distance past that index, so the delimiter, acknowledge and end-of-frame bits are never removed. The parser pulses a frame-done input at the end of each frame. This clears the history, the frame position and the stored last-data-bit index.

Every accepted raw bit also yields a raw tick. The sampler uses it to advance its timing count, whether or not the bit was forwarded.

Top module: `can_destuff`

## Requirements
- R1: After reset, `raw_tick`, `frame_valid` and `stuff_flag` are low and `frame_index` is 0.
- R2: An accepted raw bit (`raw_valid` high and `frame_done` low at a clock edge) produces a `raw_tick` pulse in the following cycle. When no raw bit is accepted, `raw_tick` stays low. Idle cycles between raw bits do not change the result.
- R3: An accepted bit that is not a stuff bit appears in the following cycle with `frame_valid` high and `frame_bit` equal to the raw value.
- R4: `frame_index` is 0 for the first forwarded bit after reset or frame-done. It rises by one for each later forwarded bit. Stuff bits leave it unchanged.
- R5: A raw bit is a stuff bit when the six most recent raw bits, oldest first and ending with it, read 000001 or 111110. Such a bit gives `stuff_flag` high and `frame_valid` low in the following cycle. `frame_valid` and `stuff_flag` are never high together.
- R6: Stuff bits stay in the raw window. A stuff bit can therefore start the next run of five equal bits.
- R7: While fewer than six raw bits have been accepted since reset or frame-done, no bit is treated as stuff.
- R8: After `tail_load` stores a value L on `tail_idx`, a raw bit is never treated as stuff if it would take frame index L+17 or above. A bit that would take index L+16 is still checked for stuff.
- R9: Until `tail_load` is seen, the stored limit is all ones. This keeps stuffing enabled at every frame index.
- R10: `frame_done` clears the raw history, the frame index and the stored limit. A raw bit or tail load in the same cycle as `frame_done` is dropped and produces no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_valid | input | 1 | A sampled raw bus bit is present |
| raw_bit | input | 1 | Sampled bus value (0 dominant, 1 recessive) |
| frame_done | input | 1 | End of frame: clear history, index and limit |
| tail_load | input | 1 | Store `tail_idx` as the last data-bit index |
| tail_idx | input | IDX_W | Frame index of the last data bit |
| frame_valid | output | 1 | A frame bit is presented |
| frame_bit | output | 1 | Value of the forwarded frame bit |
| frame_index | output | IDX_W | Position of the forwarded bit in the frame |
| stuff_flag | output | 1 | The accepted raw bit was removed as stuff |
| raw_tick | output | 1 | One raw bit was consumed (timing advance) |

## Verification
Every result of this block comes out exactly one clock after the raw bit that causes it. `raw_tick`, `frame_valid`, `stuff_flag`, `frame_bit` and `frame_index` all follow from one register stage. The driver pushes the expected outcome of each raw bit into a queue as it presents the bit. The monitor compares at the falling edge after the capturing rising edge, so each output pulse is checked against the item for the bit one cycle earlier. Any pulse with no item waiting is reported. The raw bits dropped together with `frame_done` push no item, so an output pulse from them shows up as unexpected.

// File: rtl/can_destuff_pkg.sv
package can_destuff_pkg;

    // Number of equal raw bits that forces a complementary stuff bit.
    localparam int RUN_LEN  = 5;
    // Raw window checked per incoming bit: the run plus the candidate.
    localparam int WIN_LEN  = RUN_LEN + 1;
    // Distance past the last data bit where stuffing ends.
    localparam int TAIL_GAP = 17;
    // Width of the saturating fill counter of the raw history.
    localparam int FILL_W   = $clog2(RUN_LEN + 1);

    typedef enum logic [1:0] {
        RAW_NONE  = 2'd0,
        RAW_FRAME = 2'd1,
        RAW_STUFF = 2'd2
    } raw_kind_e;

    typedef struct packed {
        raw_kind_e kind;
        logic      value;
    } raw_event_t;

    // Window bit 0 is the newest raw bit, the top bit the oldest.
    function automatic logic window_is_stuff(input logic [WIN_LEN-1:0] win);
        logic [RUN_LEN-1:0] older;
        older = win[WIN_LEN-1:1];
        return ((older == '0) &&  win[0]) ||
               ((older == '1) && !win[0]);
    endfunction

endpackage

// File: rtl/cds_history.sv
module cds_history
    import can_destuff_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               shift,
    input  logic               din,
    output logic [RUN_LEN-1:0] prior,
    output logic               primed
);

    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(RUN_LEN);

    logic [FILL_W-1:0] fill_q;

    // prior[0] is the most recent raw bit, prior[RUN_LEN-1] the oldest.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prior  <= '0;
            fill_q <= '0;
        end else if (shift) begin
            prior <= {prior[RUN_LEN-2:0], din};
            if (fill_q != FILL_FULL) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // The window is complete only once RUN_LEN real bits precede the candidate.
    assign primed = (fill_q == FILL_FULL);

endmodule

// File: rtl/cds_tail_guard.sv
module cds_tail_guard
    import can_destuff_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [IDX_W-1:0] cand_idx,
    output logic             stuff_en
);

    localparam int               CMP_W    = IDX_W + 2;
    localparam logic [IDX_W-1:0] SENTINEL = '1;

    logic [IDX_W-1:0] limit_q;
    logic [CMP_W-1:0] cand_w;
    logic [CMP_W-1:0] stop_w;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            limit_q <= SENTINEL;
        end else if (load) begin
            limit_q <= load_idx;
        end
    end

    // Widened compare so the sentinel plus the gap cannot wrap.
    assign cand_w   = CMP_W'(cand_idx);
    assign stop_w   = CMP_W'(limit_q) + CMP_W'(TAIL_GAP);
    assign stuff_en = (cand_w < stop_w);

endmodule

// File: rtl/cds_emit.sv
module cds_emit
    import can_destuff_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  raw_event_t       ev,
    output logic             frame_valid,
    output logic             frame_bit,
    output logic [IDX_W-1:0] frame_index,
    output logic             stuff_flag,
    output logic             raw_tick,
    output logic [IDX_W-1:0] next_idx
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            frame_valid <= 1'b0;
            frame_bit   <= 1'b0;
            frame_index <= '0;
            stuff_flag  <= 1'b0;
            raw_tick    <= 1'b0;
            next_idx    <= '0;
        end else begin
            raw_tick    <= (ev.kind != RAW_NONE);
            frame_valid <= (ev.kind == RAW_FRAME);
            stuff_flag  <= (ev.kind == RAW_STUFF);
            if (ev.kind == RAW_FRAME) begin
                frame_bit   <= ev.value;
                frame_index <= next_idx;
                next_idx    <= next_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_destuff.sv
module can_destuff
    import can_destuff_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_valid,
    input  logic             raw_bit,
    input  logic             frame_done,
    input  logic             tail_load,
    input  logic [IDX_W-1:0] tail_idx,
    output logic             frame_valid,
    output logic             frame_bit,
    output logic [IDX_W-1:0] frame_index,
    output logic             stuff_flag,
    output logic             raw_tick
);

    logic               accept;
    logic               primed;
    logic               stuff_en;
    logic               stuff_hit;
    logic [RUN_LEN-1:0] prior;
    logic [IDX_W-1:0]   next_idx;
    raw_event_t         ev;

    // frame_done wins over a raw bit or a tail load in the same cycle.
    assign accept = raw_valid && !frame_done;

    cds_history u_hist (
        .clk    (clk),
        .rst    (rst),
        .clear  (frame_done),
        .shift  (accept),
        .din    (raw_bit),
        .prior  (prior),
        .primed (primed)
    );

    cds_tail_guard #(.IDX_W(IDX_W)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .clear    (frame_done),
        .load     (tail_load && !frame_done),
        .load_idx (tail_idx),
        .cand_idx (next_idx),
        .stuff_en (stuff_en)
    );

    assign stuff_hit = primed && stuff_en && window_is_stuff({prior, raw_bit});

    always_comb begin
        ev.value = raw_bit;
        if (!accept) begin
            ev.kind = RAW_NONE;
        end else if (stuff_hit) begin
            ev.kind = RAW_STUFF;
        end else begin
            ev.kind = RAW_FRAME;
        end
    end

    cds_emit #(.IDX_W(IDX_W)) u_emit (
        .clk         (clk),
        .rst         (rst),
        .clear       (frame_done),
        .ev          (ev),
        .frame_valid (frame_valid),
        .frame_bit   (frame_bit),
        .frame_index (frame_index),
        .stuff_flag  (stuff_flag),
        .raw_tick    (raw_tick),
        .next_idx    (next_idx)
    );

endmodule

// File: rtl/can_destuff_chk.sv
module can_destuff_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             raw_valid,
    input logic             raw_bit,
    input logic             frame_done,
    input logic             frame_valid,
    input logic             frame_bit,
    input logic [IDX_W-1:0] frame_index,
    input logic             stuff_flag,
    input logic             raw_tick
);

    logic [IDX_W-1:0] exp_idx_q;
    logic [2:0]       gap_q;

    // Expected index of the next forwarded bit, observed at the outputs.
    always_ff @(posedge clk) begin
        if (rst || frame_done) begin
            exp_idx_q <= '0;
        end else if (frame_valid) begin
            exp_idx_q <= frame_index + 1'b1;
        end
    end

    // Raw ticks in the current equal-run window since the last stuff bit.
    always_ff @(posedge clk) begin
        if (rst || frame_done) begin
            gap_q <= '0;
        end else if (stuff_flag) begin
            gap_q <= 3'd1;
        end else if (raw_tick && gap_q != 3'd7) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_TICK_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !frame_done) |=> raw_tick);                              // R2

    AST_QUIET_WITHOUT_BIT: assert property (@(posedge clk) disable iff (rst)
        !(raw_valid && !frame_done) |=> !raw_tick);                            // R10

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        (raw_tick || frame_valid || stuff_flag) |->
            (raw_tick && $onehot({frame_valid, stuff_flag})));                 // R5

    AST_BIT_ECHO: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !frame_done) |=>
            (!frame_valid || frame_bit == $past(raw_bit)));                    // R3

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (frame_index == exp_idx_q));                           // R4

    AST_STUFF_SPACING: assert property (@(posedge clk) disable iff (rst)
        stuff_flag |-> (gap_q >= 3'd5));                                       // R7

endmodule

bind can_destuff can_destuff_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_can_destuff.sv
module sim_can_destuff;

    localparam int IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             raw_valid = 1'b0;
    logic             raw_bit = 1'b0;
    logic             frame_done = 1'b0;
    logic             tail_load = 1'b0;
    logic [IDX_W-1:0] tail_idx = '0;
    logic             frame_valid;
    logic             frame_bit;
    logic [IDX_W-1:0] frame_index;
    logic             stuff_flag;
    logic             raw_tick;

    int    checks = 0;
    int    errors = 0;
    int    exp_idx = 0;
    bit    finished = 1'b0;

    logic  q_st[$];
    logic  q_b[$];
    int    q_idx[$];
    string q_req[$];

    always #10 clk = ~clk;

    can_destuff #(.IDX_W(IDX_W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .raw_valid   (raw_valid),
        .raw_bit     (raw_bit),
        .frame_done  (frame_done),
        .tail_load   (tail_load),
        .tail_idx    (tail_idx),
        .frame_valid (frame_valid),
        .frame_bit   (frame_bit),
        .frame_index (frame_index),
        .stuff_flag  (stuff_flag),
        .raw_tick    (raw_tick)
    );

    // Driver: present one raw bit and record what it must yield.
    task automatic send(input logic b, input logic st, input string req);
        @(posedge clk); #1;
        raw_valid = 1'b1;
        raw_bit   = b;
        q_st.push_back(st);
        q_b.push_back(b);
        q_idx.push_back(exp_idx);
        q_req.push_back(req);
        if (!st) exp_idx++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            raw_valid = 1'b0;
        end
    endtask

    task automatic send_run(input int n, input logic b, input string req);
        for (int i = 0; i < n; i++) send(b, 1'b0, req);
    endtask

    task automatic send_alt(input int n, input logic first, input string req);
        for (int i = 0; i < n; i++) send(first ^ logic'(i % 2), 1'b0, req);
    endtask

    task automatic end_frame();
        @(posedge clk); #1;
        raw_valid  = 1'b0;
        frame_done = 1'b1;
        @(posedge clk); #1;
        frame_done = 1'b0;
        exp_idx    = 0;
    endtask

    // R10: a raw bit together with frame_done is dropped, so nothing is queued.
    task automatic end_frame_with_bit(input logic b);
        @(posedge clk); #1;
        raw_valid  = 1'b1;
        raw_bit    = b;
        frame_done = 1'b1;
        @(posedge clk); #1;
        raw_valid  = 1'b0;
        frame_done = 1'b0;
        exp_idx    = 0;
    endtask

    task automatic load_tail(input int v);
        @(posedge clk); #1;
        raw_valid = 1'b0;
        tail_load = 1'b1;
        tail_idx  = IDX_W'(v);
        @(posedge clk); #1;
        tail_load = 1'b0;
    endtask

    task automatic check_quiet(input string req);
        @(negedge clk);
        checks++;
        if (raw_tick || frame_valid || stuff_flag) begin
            errors++;
            $display("FAIL %s quiet: got tick=%0b valid=%0b stuff=%0b expected 0 0 0",
                     req, raw_tick, frame_valid, stuff_flag);
        end
    endtask

    // Monitor: every output pulse is matched against the oldest queued item.
    always @(negedge clk) begin
        if (!rst && (raw_tick || frame_valid || stuff_flag)) begin
            checks++;
            if (q_st.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected pulse: got tick=%0b valid=%0b stuff=%0b expected none",
                         raw_tick, frame_valid, stuff_flag);
            end else begin
                logic  st, b;
                int    idx;
                string req;
                st  = q_st.pop_front();
                b   = q_b.pop_front();
                idx = q_idx.pop_front();
                req = q_req.pop_front();
                if (!raw_tick || frame_valid != !st || stuff_flag != st ||
                    (!st && (frame_bit != b || int'(frame_index) != idx))) begin
                    errors++;
                    $display("FAIL %s: got tick=%0b valid=%0b stuff=%0b bit=%0b idx=%0d expected tick=1 valid=%0b stuff=%0b bit=%0b idx=%0d",
                             req, raw_tick, frame_valid, stuff_flag, frame_bit,
                             frame_index, !st, st, b, idx);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: got no completion expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        checks++;
        if (raw_tick || frame_valid || stuff_flag || frame_index != '0) begin
            errors++;
            $display("FAIL R1: got tick=%0b valid=%0b stuff=%0b idx=%0d expected 0 0 0 0",
                     raw_tick, frame_valid, stuff_flag, frame_index);
        end

        // R7: a lone 1 right after reset has no full window
        send(1'b1, 1'b0, "R7");
        idle(2);
        check_quiet("R2");

        // R7, R3, R4: four zeros then a one is only five raw bits
        end_frame();
        send_run(4, 1'b0, "R7");
        send(1'b1, 1'b0, "R7");
        idle(1);                              // R2: a gap changes nothing
        send_run(4, 1'b1, "R3");
        // R5: 111110 -> stuff
        send(1'b0, 1'b1, "R5");
        // R6: the stuff zero starts the next run
        send_run(4, 1'b0, "R6");
        send(1'b1, 1'b1, "R6");
        send(1'b0, 1'b0, "R4");
        idle(2);

        // R8: limit 3 -> index 19 is still checked
        end_frame();
        load_tail(3);
        send_alt(14, 1'b0, "R8");
        send_run(5, 1'b0, "R8");
        send(1'b1, 1'b1, "R8");
        idle(2);

        // R8: limit 3 -> index 20 is past the stuffing region
        end_frame();
        load_tail(3);
        send_alt(15, 1'b1, "R8");
        send_run(5, 1'b0, "R8");
        send(1'b1, 1'b0, "R8");
        idle(2);

        // R9, R10: frame_done restores the sentinel, deep index still stuffs
        end_frame();
        send_alt(40, 1'b0, "R9");
        send_run(5, 1'b0, "R9");
        send(1'b1, 1'b1, "R9");
        send(1'b0, 1'b0, "R9");
        idle(2);

        // R10: a bit dropped with frame_done; history and index are cleared
        end_frame();
        send_run(4, 1'b1, "R10");
        end_frame_with_bit(1'b1);
        check_quiet("R10");
        send(1'b0, 1'b0, "R10");
        idle(3);
        check_quiet("R2");

        checks++;
        if (q_st.size() != 0) begin
            errors++;
            $display("FAIL R2 missing pulses: got %0d outstanding expected 0", q_st.size());
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule